// File: doc/BRIEF.md
# Synchronous FIFO with Quadrant-Tracked Flags

This block is a single-clock first-in first-out buffer whose read and write pointers are only as wide as the storage address. With pointers of that width, equal pointers can mean either an empty or a full buffer. A one-bit flag state settles which. It records the half of the occupancy range that the pointer difference last visited. When the difference is in its second quarter the state reads "low". When it is in its third quarter the state reads "high". In the first and last quarters the state keeps its value. A zero difference then means empty under "low" and full under "high".

The producer presents data with a write enable. The consumer sees the oldest stored word on the read data port while the buffer is not empty, and takes it with a read enable. The flag state is brought out as two complementary indications, one for near-full and one for near-empty. Writes into a full buffer are dropped, and so are reads from an empty one. The depth is 2^ADDR_W, and ADDR_W must be at least 2.

Top module: `qf_fifo`

## Requirements
- R1: After a synchronous active-high reset both pointers are zero and the flag state is "low": empty_o=1, full_o=0, almost_empty_o=1, almost_full_o=0.
- R2: Words leave in the order they were accepted. While empty_o=0, rd_data_o shows the oldest stored word, with no cycle of read latency.
- R3: empty_o is 1 exactly when write pointer minus read pointer (mod 2^ADDR_W) is zero and the flag state is "low".
- R4: full_o is 1 exactly when the pointer difference is zero and the flag state is "high".
- R5: At a clock edge where the two top bits of the pointer difference are 2'b10, the flag state becomes "high", shown as almost_full_o=1 from that edge.
- R6: At a clock edge where the two top bits of the pointer difference are 2'b01, the flag state becomes "low", shown as almost_empty_o=1 from that edge.
- R7: At a clock edge where the two top bits of the difference are 2'b00 or 2'b11, the flag state keeps its value.
- R8: A write while full_o=1 is ignored. The stored contents and the write pointer do not change.
- R9: A read while empty_o=1 is ignored. The read pointer does not move.
- R10: A write and a read in the same cycle, with the buffer neither full nor empty, leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Producer write request |
| wr_data_i | input | DATA_W | Word to store |
| rd_en_i | input | 1 | Consumer read request |
| rd_data_o | output | DATA_W | Oldest stored word (first-word fall-through) |
| full_o | output | 1 | No free location |
| empty_o | output | 1 | No stored word |
| almost_full_o | output | 1 | Flag state is "high" |
| almost_empty_o | output | 1 | Flag state is "low" |

## Verification
The pointers, the storage and the flag state each change at the edge that accepts a stimulus. empty_o, full_o and rd_data_o are combinational from those registers, so they are due at that same edge. The near-full and near-empty indications lag by one further edge: they switch at the first edge at which the registered difference already sits in the new quarter. The bench drives inputs at the falling edge and updates its occupancy and flag-state model at the rising edge, using the occupancy from before that edge. It samples every output one nanosecond after the rising edge, so each result is compared in the cycle in which it is due.

// File: rtl/qf_fifo_pkg.sv
package qf_fifo_pkg;

    // Flag state: which half of the occupancy range was last visited.
    typedef enum logic {
        QS_LOW  = 1'b0,
        QS_HIGH = 1'b1
    } qstate_e;

    // Quarter of the pointer difference, from its two top bits.
    typedef enum logic [1:0] {
        QD_FIRST  = 2'b00,
        QD_SECOND = 2'b01,
        QD_THIRD  = 2'b10,
        QD_FOURTH = 2'b11
    } quarter_e;

    typedef struct packed {
        logic wr_ok;
        logic rd_ok;
    } xfer_t;

    function automatic qstate_e next_qstate(input quarter_e q, input qstate_e cur);
        qstate_e nxt;
        case (q)
            QD_SECOND: nxt = QS_LOW;
            QD_THIRD:  nxt = QS_HIGH;
            default:   nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/qf_ptr.sv
module qf_ptr #(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_i,
    output logic [ADDR_W-1:0] ptr_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_o <= '0;
        end else if (adv_i) begin
            ptr_o <= ptr_o + 1'b1;
        end
    end
endmodule

// File: rtl/qf_store.sv
module qf_store #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/qf_track.sv
module qf_track
    import qf_fifo_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] diff_i,
    output qstate_e           state_o
);
    quarter_e quarter;

    assign quarter = quarter_e'(diff_i[ADDR_W-1 -: 2]);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_o <= QS_LOW;
        end else begin
            state_o <= next_qstate(quarter, state_o);
        end
    end

    assert_enter_high_R5: assert property (@(posedge clk) disable iff (rst)
        (diff_i[ADDR_W-1 -: 2] == 2'b10) |=> (state_o == QS_HIGH));

    assert_enter_low_R6: assert property (@(posedge clk) disable iff (rst)
        (diff_i[ADDR_W-1 -: 2] == 2'b01) |=> (state_o == QS_LOW));

    assert_hold_state_R7: assert property (@(posedge clk) disable iff (rst)
        (diff_i[ADDR_W-1] == diff_i[ADDR_W-2]) |=> $stable(state_o));
endmodule

// File: rtl/qf_fifo.sv
module qf_fifo
    import qf_fifo_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              full_o,
    output logic              empty_o,
    output logic              almost_full_o,
    output logic              almost_empty_o
);
    generate
        if (ADDR_W < 2) begin : g_bad_addr_w
            $error("qf_fifo: ADDR_W must be at least 2");
        end
    endgenerate

    logic [ADDR_W-1:0] wptr;
    logic [ADDR_W-1:0] rptr;
    logic [ADDR_W-1:0] diff;
    logic              diff_zero;
    qstate_e           qstate;
    xfer_t             xfer;

    assign diff      = wptr - rptr;
    assign diff_zero = (diff == '0);

    assign empty_o        = diff_zero && (qstate == QS_LOW);
    assign full_o         = diff_zero && (qstate == QS_HIGH);
    assign almost_full_o  = (qstate == QS_HIGH);
    assign almost_empty_o = (qstate == QS_LOW);

    assign xfer.wr_ok = wr_en_i && !full_o;
    assign xfer.rd_ok = rd_en_i && !empty_o;

    qf_ptr #(.ADDR_W(ADDR_W)) i_wptr (
        .clk   (clk),
        .rst   (rst),
        .adv_i (xfer.wr_ok),
        .ptr_o (wptr)
    );

    qf_ptr #(.ADDR_W(ADDR_W)) i_rptr (
        .clk   (clk),
        .rst   (rst),
        .adv_i (xfer.rd_ok),
        .ptr_o (rptr)
    );

    qf_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_store (
        .clk     (clk),
        .we_i    (xfer.wr_ok),
        .waddr_i (wptr),
        .wdata_i (wr_data_i),
        .raddr_i (rptr),
        .rdata_o (rd_data_o)
    );

    qf_track #(.ADDR_W(ADDR_W)) i_track (
        .clk     (clk),
        .rst     (rst),
        .diff_i  (diff),
        .state_o (qstate)
    );

    assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        !(full_o && empty_o));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        (full_o && wr_en_i) |=> (wptr == $past(wptr)));

    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (rst)
        (empty_o && rd_en_i) |=> (rptr == $past(rptr)));

    assert_balanced_xfer_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && rd_en_i && !full_o && !empty_o) |=> (diff == $past(diff)));
endmodule

// File: tb/test_qf_fifo.sv
module test_qf_fifo;
    localparam int DW    = 8;
    localparam int AW    = 3;
    localparam int DEPTH = 1 << AW;
    localparam int NVEC  = 16;

    // Vector fields: {wr, rd, data}
    localparam logic [DW+1:0] VEC [NVEC] = '{
        {2'b10, 8'h11}, {2'b10, 8'h22}, {2'b10, 8'h33}, {2'b10, 8'h44},
        {2'b10, 8'h55}, {2'b10, 8'h66}, {2'b10, 8'h77}, {2'b10, 8'h88},
        {2'b10, 8'h99}, {2'b11, 8'hAA}, {2'b01, 8'h00}, {2'b11, 8'hBB},
        {2'b01, 8'h00}, {2'b01, 8'h00}, {2'b01, 8'h00}, {2'b01, 8'h00}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          full, empty, afull, aempty;

    int checks = 0;
    int errors = 0;

    // Bench model
    logic [DW-1:0] mq[$];
    int            m_cnt = 0;
    logic          m_high = 1'b0;

    always #2 clk = ~clk;

    qf_fifo #(.DATA_W(DW), .ADDR_W(AW)) i_qf_fifo (
        .clk            (clk),
        .rst            (rst),
        .wr_en_i        (wr_en),
        .wr_data_i      (wr_data),
        .rd_en_i        (rd_en),
        .rd_data_o      (rd_data),
        .full_o         (full),
        .empty_o        (empty),
        .almost_full_o  (afull),
        .almost_empty_o (aempty)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_all();
        chk("R3 empty", int'(empty), int'(m_cnt == 0));
        chk("R4 full", int'(full), int'(m_cnt == DEPTH));
        chk("R5 almost_full", int'(afull), int'(m_high));
        chk("R6 almost_empty", int'(aempty), int'(!m_high));
        if (m_cnt > 0) chk("R2 head data", int'(rd_data), int'(mq[0]));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        mq.delete(); m_cnt = 0; m_high = 1'b0;
        #1;
        chk("R1 empty after reset", int'(empty), 1);
        chk("R1 full after reset", int'(full), 0);
        chk("R1 almost_empty after reset", int'(aempty), 1);
        chk("R1 almost_full after reset", int'(afull), 0);
    endtask

    task automatic step(input logic w, input logic r, input logic [DW-1:0] d);
        logic wacc, racc;
        int   quad;
        @(negedge clk);
        wr_en = w; rd_en = r; wr_data = d;
        @(posedge clk);
        wacc = w && (m_cnt != DEPTH);
        racc = r && (m_cnt != 0);
        quad = (m_cnt % DEPTH) >> (AW - 2);
        if (quad == 1) m_high = 1'b0;
        else if (quad == 2) m_high = 1'b1;
        if (racc) void'(mq.pop_front());
        if (wacc) mq.push_back(d);
        m_cnt = m_cnt + int'(wacc) - int'(racc);
        #1;
        wr_en = 1'b0; rd_en = 1'b0;
        chk_all();
    endtask

    initial begin : watchdog
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [DW-1:0] head;
        do_reset();

        // Vector table walk (covers R2..R6, R8 at entry 9)
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][DW+1], VEC[i][DW], VEC[i][DW-1:0]);
        end

        // R8: write into a full buffer changes nothing
        do_reset();
        for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, DW'(8'h30 + i));
        chk("R8 full before extra write", int'(full), 1);
        head = rd_data;
        step(1'b1, 1'b0, 8'hEE);
        chk("R8 full held", int'(full), 1);
        chk("R8 head unchanged", int'(rd_data), int'(head));
        for (int i = 0; i < DEPTH; i++) begin
            chk("R8 order kept", int'(rd_data), 8'h30 + i);
            step(1'b0, 1'b1, 8'h00);
        end
        chk("R8 empty after exactly DEPTH reads", int'(empty), 1);

        // R9: read from empty buffer is ignored
        step(1'b0, 1'b1, 8'h00);
        chk("R9 still empty", int'(empty), 1);
        step(1'b1, 1'b0, 8'h5A);
        chk("R9 new word at head", int'(rd_data), 8'h5A);
        step(1'b0, 1'b1, 8'h00);
        chk("R9 empty after single read", int'(empty), 1);

        // R10: balanced transfers keep occupancy
        do_reset();
        step(1'b1, 1'b0, 8'hA1);
        step(1'b1, 1'b0, 8'hA2);
        step(1'b1, 1'b0, 8'hA3);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, DW'(8'hC0 + i));
        step(1'b0, 1'b1, 8'h00);
        step(1'b0, 1'b1, 8'h00);
        chk("R10 one word left", int'(empty), 0);
        chk("R10 last word", int'(rd_data), 8'hC3);
        step(1'b0, 1'b1, 8'h00);
        chk("R10 empty after three reads", int'(empty), 1);

        // R7: hold in first and fourth quarters
        do_reset();
        step(1'b1, 1'b0, 8'h01);
        step(1'b1, 1'b0, 8'h02);
        chk("R7 low held at count 2", int'(aempty), 1);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, DW'(8'h03 + i));
        chk("R7 high at count 7", int'(afull), 1);
        step(1'b0, 1'b1, 8'h00);
        step(1'b0, 1'b1, 8'h00);
        chk("R7 high held at count 5", int'(afull), 1);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 8'h00);
        chk("R7 low held at count 1", int'(aempty), 1);
        chk("R7 not empty at count 1", int'(empty), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule